// File: doc/BRIEF.md
# Timer Capture-and-Clear Unit

This block pairs a 16-bit up/down timer with a capture register. An external trigger pin is brought into the clock domain through a synchronizer. Its edges are then qualified by a 2-bit edge selector. When a qualifying edge arrives, the unit can do three things: copy the running count into the capture register, raise a sticky interrupt flag, and zero the timer. Copying and zeroing have separate enables. With copying disabled, the trigger still sets the flag and can still clear the timer.

An alternate-trigger mode takes the trigger from the count and/or direction lines of a neighbouring timer instead of the pin. The same edge selector applies in that mode. This lets software measure the time between transitions on those lines. Timer stepping comes from two plain inputs, an enable and a direction.

Software uses a small register port. Writes take effect at the next clock edge, and reads are combinational. All pins are plain levels. There is no streamed data, so nothing in the block applies back-pressure.

Top module: `capture_clear_unit`

## Requirements
- R1: After reset the control register, timer, capture register and flag are all zero, and `irq_o` is low.
- R2: A level change on a trigger input that is first sampled at clock edge n takes effect at edge n+2. Nothing it causes is visible before that edge.
- R3: On a qualifying edge with capture enabled, the capture register takes the timer value held just before that edge, and the flag is set.
- R4: The edge selector is control bits [1:0]: 0 means no edge, 1 rising, 2 falling, 3 both. A transition that is not selected changes neither the capture register, the timer nor the flag.
- R5: With clear-on-capture (control bit 3) set, a qualifying edge leaves the timer at 0x0000. With it clear, the timer keeps counting unaffected.
- R6: With capture enable (control bit 2) clear, a qualifying edge leaves the capture register unchanged, still sets the flag, and still clears the timer when bit 3 is set.
- R7: Writing a value with bit 0 set to address 3 clears the flag. `irq_o` always equals the flag.
- R8: With alternate mode (control bit 4) set, the trigger pin is ignored. Control bits [6:5] choose which neighbour lines are watched: bit 5 the count line, bit 6 the direction line.
- R9: If a timer step and a clear fall in the same cycle, the timer ends at 0x0000 and the captured value is the count before that step.
- R10: If a flag-clear write and a qualifying edge fall in the same cycle, the flag stays set.
- R11: With `cnt_en_i` high the timer moves by one per cycle, up when `cnt_up_i` is 1 and down otherwise, wrapping modulo 2^16. With `cnt_en_i` low it holds.
- R12: The register map is: address 0 control, address 1 timer (write loads it, but a clear in the same cycle wins), address 2 capture (read-only), address 3 flag in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_pin_i | input | 1 | External trigger pin, asynchronous |
| nb_cnt_i | input | 1 | Neighbour timer count line, asynchronous |
| nb_dir_i | input | 1 | Neighbour timer direction line, asynchronous |
| cnt_en_i | input | 1 | Timer step enable |
| cnt_up_i | input | 1 | Step direction, 1 = up |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data for `reg_addr_i` |
| irq_o | output | 1 | Capture interrupt request (the flag) |

## Verification
Two pairs of functions can land in the same cycle.

The first pair is a timer step and a clear-on-capture. The bench loads the timer, keeps stepping enabled and raises the pin in the same cycle, then stops stepping right after the trigger edge. It expects the capture to hold the load value plus one and the timer to read zero.

The second pair is a flag-clear write and a new trigger. The bench times the clear write to land on the exact edge where the trigger, two edges after the pin change, takes effect. It expects the flag to stay set.

// File: rtl/cap_pkg.sv
package cap_pkg;
  localparam int REG_AW = 2;

  localparam logic [REG_AW-1:0] ADDR_CTRL  = 2'd0;
  localparam logic [REG_AW-1:0] ADDR_COUNT = 2'd1;
  localparam logic [REG_AW-1:0] ADDR_CAPT  = 2'd2;
  localparam logic [REG_AW-1:0] ADDR_FLAG  = 2'd3;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_BOTH = 2'd3
  } edge_sel_e;

  typedef struct packed {
    logic [1:0] alt_src;
    logic       alt_mode;
    logic       clr_on_cap;
    logic       cap_en;
    edge_sel_e  edge_sel;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  localparam int SRC_PIN = 0;
  localparam int SRC_CNT = 1;
  localparam int SRC_DIR = 2;
  localparam int N_SRC   = 3;
endpackage

// File: rtl/cap_edge_det.sv
module cap_edge_det #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw_i,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  localparam int DEPTH = STAGES + 1;

  logic [DEPTH-1:0][N-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[DEPTH-2:0], raw_i};
  end

  generate
    for (genvar b = 0; b < N; b++) begin : g_bit
      assign rise_o[b] =  chain_q[STAGES-1][b] & ~chain_q[STAGES][b];
      assign fall_o[b] = ~chain_q[STAGES-1][b] &  chain_q[STAGES][b];
    end
  endgenerate
endmodule

// File: rtl/cap_trig_sel.sv
module cap_trig_sel
  import cap_pkg::*;
(
  input  ctrl_t            ctrl_i,
  input  logic [N_SRC-1:0] rise_i,
  input  logic [N_SRC-1:0] fall_i,
  output logic             trig_o
);
  logic [N_SRC-1:0] hit;

  generate
    for (genvar s = 0; s < N_SRC; s++) begin : g_hit
      assign hit[s] = (ctrl_i.edge_sel[0] & rise_i[s]) |
                      (ctrl_i.edge_sel[1] & fall_i[s]);
    end
  endgenerate

  always_comb begin
    if (ctrl_i.alt_mode)
      trig_o = (ctrl_i.alt_src[0] & hit[SRC_CNT]) |
               (ctrl_i.alt_src[1] & hit[SRC_DIR]);
    else
      trig_o = hit[SRC_PIN];
  end
endmodule

// File: rtl/cap_timer.sv
module cap_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          load_i,
  input  logic [TW-1:0] load_val_i,
  input  logic          step_i,
  input  logic          up_i,
  output logic [TW-1:0] count_o
);
  localparam logic [TW-1:0] ONE = TW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count_o <= '0;
    else if (clr_i)  count_o <= '0;
    else if (load_i) count_o <= load_val_i;
    else if (step_i) count_o <= up_i ? count_o + ONE : count_o - ONE;
  end
endmodule

// File: rtl/capture_clear_unit.sv
module capture_clear_unit
  import cap_pkg::*;
#(
  parameter int TW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_pin_i,
  input  logic              nb_cnt_i,
  input  logic              nb_dir_i,
  input  logic              cnt_en_i,
  input  logic              cnt_up_i,
  input  logic              reg_wr_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [TW-1:0]     reg_wdata_i,
  output logic [TW-1:0]     reg_rdata_o,
  output logic              irq_o
);
  localparam int PAD_W = TW - CTRL_W;

  ctrl_t            ctrl_q;
  logic [TW-1:0]    count;
  logic [TW-1:0]    capt_q;
  logic             flag_q;
  logic [N_SRC-1:0] raw_in, rise, fall;
  logic             trig;
  logic             wr_ctrl, wr_count, wr_flag_clr;
  logic             clr_now, latch_now;

  assign raw_in[SRC_PIN] = cap_pin_i;
  assign raw_in[SRC_CNT] = nb_cnt_i;
  assign raw_in[SRC_DIR] = nb_dir_i;

  cap_edge_det #(.N(N_SRC), .STAGES(SYNC_STAGES)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw_i  (raw_in),
    .rise_o (rise),
    .fall_o (fall)
  );

  cap_trig_sel u_sel (
    .ctrl_i (ctrl_q),
    .rise_i (rise),
    .fall_i (fall),
    .trig_o (trig)
  );

  assign wr_ctrl     = reg_wr_i && (reg_addr_i == ADDR_CTRL);
  assign wr_count    = reg_wr_i && (reg_addr_i == ADDR_COUNT);
  assign wr_flag_clr = reg_wr_i && (reg_addr_i == ADDR_FLAG) && reg_wdata_i[0];
  assign clr_now     = trig && ctrl_q.clr_on_cap;
  assign latch_now   = trig && ctrl_q.cap_en;

  cap_timer #(.TW(TW)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (clr_now),
    .load_i     (wr_count),
    .load_val_i (reg_wdata_i),
    .step_i     (cnt_en_i),
    .up_i       (cnt_up_i),
    .count_o    (count)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= ctrl_t'(reg_wdata_i[CTRL_W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         capt_q <= '0;
    else if (latch_now) capt_q <= count;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           flag_q <= 1'b0;
    else if (trig)        flag_q <= 1'b1;
    else if (wr_flag_clr) flag_q <= 1'b0;
  end

  always_comb begin
    unique case (reg_addr_i)
      ADDR_CTRL:  reg_rdata_o = {{PAD_W{1'b0}}, ctrl_q};
      ADDR_COUNT: reg_rdata_o = count;
      ADDR_CAPT:  reg_rdata_o = capt_q;
      default:    reg_rdata_o = {{(TW-1){1'b0}}, flag_q};
    endcase
  end

  assign irq_o = flag_q;
endmodule

// File: rtl/cap_checker.sv
module cap_checker #(
  parameter int TW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          trig,
  input logic          cap_en,
  input logic          clr_on,
  input logic          flag_clr,
  input logic          load,
  input logic          cnt_en,
  input logic          cnt_up,
  input logic [TW-1:0] count,
  input logic [TW-1:0] capt,
  input logic          flag
);
  assert_flag_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> flag);

  assert_capt_value_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && cap_en) |=> (capt == $past(count)));

  assert_capt_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(trig && cap_en) |=> $stable(capt));

  assert_timer_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && clr_on) |=> (count == '0));

  assert_set_beats_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && flag_clr) |=> flag);

  assert_step_up_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!(trig && clr_on) && !load && cnt_en && cnt_up) |=> (count == TW'($past(count) + 1'b1)));

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!(trig && clr_on) && !load && !cnt_en) |=> $stable(count));
endmodule

bind capture_clear_unit cap_checker #(.TW(TW)) u_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .trig     (trig),
  .cap_en   (ctrl_q.cap_en),
  .clr_on   (ctrl_q.clr_on_cap),
  .flag_clr (wr_flag_clr),
  .load     (wr_count),
  .cnt_en   (cnt_en_i),
  .cnt_up   (cnt_up_i),
  .count    (count),
  .capt     (capt_q),
  .flag     (flag_q)
);

// File: tb/tb_capture_clear_unit.sv
`timescale 1ns/1ps
module tb_capture_clear_unit;
  import cap_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cap_pin = 1'b0, nb_cnt = 1'b0, nb_dir = 1'b0;
  logic        cnt_en = 1'b0, cnt_up = 1'b1;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = ADDR_CTRL;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        irq;

  always #2 clk = ~clk;

  capture_clear_unit dut (
    .clk(clk), .rst_n(rst_n), .cap_pin_i(cap_pin), .nb_cnt_i(nb_cnt),
    .nb_dir_i(nb_dir), .cnt_en_i(cnt_en), .cnt_up_i(cnt_up),
    .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .irq_o(irq)
  );

  typedef struct {
    logic [15:0] capt;
    logic [15:0] cnt;
    logic        flag;
    string       tag;
  } exp_t;

  exp_t        sb_q[$];
  int          checks = 0, errors = 0;
  bit          done = 1'b0;
  logic [15:0] e_capt = '0, e_cnt = '0;
  logic        e_flag = 1'b0;

  task automatic cmp(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // monitor: pops expected items and reads the register port
  initial begin
    forever begin
      exp_t it;
      wait (sb_q.size() != 0);
      it = sb_q[0];
      #0.1 reg_addr = ADDR_CAPT;
      #0.3 cmp(it.tag, "capture", reg_rdata, it.capt);
      reg_addr = ADDR_COUNT;
      #0.3 cmp(it.tag, "count", reg_rdata, it.cnt);
      reg_addr = ADDR_FLAG;
      #0.3 cmp(it.tag, "flag", reg_rdata, {15'd0, it.flag});
      cmp(it.tag, "irq", {15'd0, irq}, {15'd0, it.flag});
      void'(sb_q.pop_front());
    end
  end

  task automatic expect_now(input string tag);
    exp_t it;
    it.capt = e_capt; it.cnt = e_cnt; it.flag = e_flag; it.tag = tag;
    sb_q.push_back(it);
    wait (sb_q.size() == 0);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic clear_flag();
    wr(ADDR_FLAG, 16'h0001);
    e_flag = 1'b0;
  endtask

  initial begin
    #800000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    expect_now("R1 reset");

    // rising edge, capture enabled, no clear
    wr(ADDR_CTRL, 16'h0005);
    wr(ADDR_COUNT, 16'h1234); e_cnt = 16'h1234;
    expect_now("R12 load");
    @(negedge clk); cap_pin = 1'b1;
    repeat (2) @(negedge clk);
    expect_now("R2 not before edge n+2");
    @(negedge clk);
    e_capt = 16'h1234; e_flag = 1'b1;
    expect_now("R3 capture");

    clear_flag();
    expect_now("R7 flag clear");
    @(negedge clk); cap_pin = 1'b0; settle();
    expect_now("R4 falling ignored in rising mode");

    // falling edge with clear
    wr(ADDR_CTRL, 16'h000E);
    wr(ADDR_COUNT, 16'h0055); e_cnt = 16'h0055;
    @(negedge clk); cap_pin = 1'b1; settle();
    expect_now("R4 rising ignored in falling mode");
    @(negedge clk); cap_pin = 1'b0; settle();
    e_capt = 16'h0055; e_cnt = 16'h0000; e_flag = 1'b1;
    expect_now("R5 clear on capture");

    // capture disabled, clear still active
    clear_flag();
    wr(ADDR_CTRL, 16'h000B);
    wr(ADDR_COUNT, 16'h0ABC);
    @(negedge clk); cap_pin = 1'b1; settle();
    e_cnt = 16'h0000; e_flag = 1'b1;
    expect_now("R6 capture disabled");

    // edge select none
    clear_flag();
    wr(ADDR_CTRL, 16'h0004);
    wr(ADDR_COUNT, 16'h0777); e_cnt = 16'h0777;
    @(negedge clk); cap_pin = 1'b0; settle();
    @(negedge clk); cap_pin = 1'b1; settle();
    expect_now("R4 none selected");

    // alternate mode, count line only
    wr(ADDR_CTRL, 16'h0037);
    wr(ADDR_COUNT, 16'h0300); e_cnt = 16'h0300;
    @(negedge clk); cap_pin = 1'b0; settle();
    expect_now("R8 pin ignored");
    @(negedge clk); nb_cnt = 1'b1; settle();
    e_capt = 16'h0300; e_flag = 1'b1;
    expect_now("R8 count line");
    clear_flag();
    // alternate mode, direction line only
    wr(ADDR_CTRL, 16'h0057);
    wr(ADDR_COUNT, 16'h0400); e_cnt = 16'h0400;
    @(negedge clk); nb_cnt = 1'b0; settle();
    expect_now("R8 count line ignored");
    @(negedge clk); nb_dir = 1'b1; settle();
    e_capt = 16'h0400; e_flag = 1'b1;
    expect_now("R8 direction line");

    // step and clear in the same cycle
    clear_flag();
    wr(ADDR_CTRL, 16'h000D);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = ADDR_COUNT; reg_wdata = 16'h2000;
    cnt_en = 1'b1; cnt_up = 1'b1; cap_pin = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
    @(negedge clk);
    @(negedge clk); cnt_en = 1'b0;
    e_capt = 16'h2001; e_cnt = 16'h0000; e_flag = 1'b1;
    expect_now("R9 step and clear");

    // flag clear write meets a new trigger
    @(negedge clk); cap_pin = 1'b0; settle();
    @(negedge clk); cap_pin = 1'b1;
    @(negedge clk);
    @(negedge clk); reg_wr = 1'b1; reg_addr = ADDR_FLAG; reg_wdata = 16'h0001;
    @(negedge clk); reg_wr = 1'b0;
    e_capt = 16'h0000; e_flag = 1'b1;
    expect_now("R10 set beats clear");
    clear_flag();
    expect_now("R7 clear afterwards");

    // wrap and hold
    wr(ADDR_CTRL, 16'h0000);
    wr(ADDR_COUNT, 16'hFFFF);
    @(negedge clk); cnt_en = 1'b1; cnt_up = 1'b1;
    @(negedge clk); cnt_en = 1'b0;
    e_cnt = 16'h0000;
    expect_now("R11 up wrap");
    wr(ADDR_COUNT, 16'h0000);
    @(negedge clk); cnt_en = 1'b1; cnt_up = 1'b0;
    @(negedge clk); cnt_en = 1'b0;
    e_cnt = 16'hFFFF;
    expect_now("R11 down wrap");
    cnt_up = 1'b1;
    repeat (3) @(negedge clk);
    expect_now("R11 hold");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule